// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the raw D+ and D− lines of a low-speed USB bus, sampled by a 16 MHz system clock, and turns each incoming packet into a stream of bytes. Both lines first pass through two-flop synchronisers. The receiver then hunts for a J-to-K transition. It accepts that transition as the end of the sync field only when the line is still K one bit later, which is the double K that closes sync. Otherwise it goes back to hunting. After lock it samples at bit centres. The bit period is 32/3 clocks, so a fractional phase generator spaces the samples 10 or 11 clocks apart and holds the exact average. Each sample is decoded from NRZI, stuffed bits are dropped, and bits are packed LSB first into bytes.

Each completed byte leaves on a one-cycle write port that carries the data, a strobe and the buffer index. The buffer itself sits outside the block. An SE0 at a sample point closes the packet, and the block pulses an end strobe together with the number of bytes stored. Two conditions abandon a packet. A byte beyond the buffer depth raises an overflow strobe, and failing to lock within a window of clocks raises a sync error strobe. In both cases the receiver ignores the line until the next SE0.

Top module: `lsusb_rx`

## Requirements
- R1: During and after synchronous reset every output is 0 and the receiver waits for a J-to-K transition. Line codes on {dp_i, dm_i} are J = 01, K = 10 and SE0 = 00.
- R2: Lock happens only when the line is K at the check point 16 clocks after a J-to-K transition. If the line is not K there, the receiver resumes hunting, so extra leading K-J pairs before the double K are tolerated.
- R3: If no lock occurs within SYNC_WINDOW clocks of the first J-to-K transition, sync_err_o pulses for one cycle. Nothing is written, no end strobe follows, and the line is ignored until an SE0 is seen.
- R4: NRZI decoding gives 1 when the sampled level equals the previous bit's level and 0 when it differs. The first data bit is compared against the final K of sync.
- R5: After six consecutive decoded 1 bits, the next bit is discarded. The final 1 of the sync field counts toward the six.
- R6: Bits are assembled LSB first. Each completed byte produces a one-cycle wr_en_o with wr_data_o, and wr_addr_o counts 0, 1, 2 and so on within the packet.
- R7: SE0 at a sample point pulses eop_o for one cycle, and rx_len_o in that cycle equals the number of bytes written. Bits of an incomplete trailing byte are discarded.
- R8: A byte that would be number BUF_DEPTH+1 is not written. ovf_o pulses for one cycle, no end strobe follows for that packet, and the receiver waits for SE0.
- R9: The first data sample comes 11 clocks after the lock check. Later samples are 10 or 11 clocks apart, and any three consecutive gaps total CLK_NUM (32) clocks, so long packets decode without drift.
- R10: At most one of wr_en_o, eop_o, ovf_o and sync_err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | Raw D+ line, asynchronous |
| dm_i | input | 1 | Raw D− line, asynchronous |
| wr_en_o | output | 1 | Write strobe for one received byte |
| wr_addr_o | output | $clog2(BUF_DEPTH) | Buffer index of the byte being written |
| wr_data_o | output | 8 | Received byte |
| eop_o | output | 1 | End-of-packet strobe |
| rx_len_o | output | $clog2(BUF_DEPTH+1) | Bytes stored, valid with eop_o |
| ovf_o | output | 1 | Buffer overflow strobe |
| sync_err_o | output | 1 | Sync search timeout strobe |

## Verification
A sample phase that drifts shows up within two or three bytes of a long packet, as corrupted wr_data_o values. A mis-counted run of ones shows up in the byte that follows a run of six 1s: one bit is duplicated or lost, which shifts every later byte. A wrong lock decision either produces writes from a packet that should have timed out, or the expected bytes never appear before the end strobe. Errors in the byte counter are visible on the very next write address and on rx_len_o in the end-strobe cycle.

// File: rtl/lsusb_rx_pkg.sv
package lsusb_rx_pkg;

  // Receiver control states
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HUNT    = 3'd1,
    ST_CONFIRM = 3'd2,
    ST_RECV    = 3'd3,
    ST_DRAIN   = 3'd4
  } rx_state_t;

  // Line state as {D+, D-}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

endpackage

// File: rtl/lsusb_rx_sync.sv
module lsusb_rx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/lsusb_rx_phase.sv
module lsusb_rx_phase #(
  parameter int CLK_NUM  = 32,
  parameter int CLK_DEN  = 3,
  parameter int CONF_DLY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic enable_i,
  output logic tick_o
);
  localparam int BASE      = CLK_NUM / CLK_DEN;
  localparam int REM       = CLK_NUM % CLK_DEN;
  localparam int FRAC_INIT = (REM == 0) ? 0 : CLK_DEN - REM;
  localparam int TMAX      = (CONF_DLY > BASE + 1) ? CONF_DLY : BASE + 1;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int FW        = $clog2(2 * CLK_DEN);

  logic [TW-1:0] tmr;
  logic [FW-1:0] frac, frac_sum;
  logic          extra;

  assign tick_o   = enable_i && (tmr == TW'(1));
  assign frac_sum = frac + FW'(REM);
  assign extra    = (frac_sum >= FW'(CLK_DEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr  <= '0;
      frac <= '0;
    end else if (restart_i) begin
      tmr  <= TW'(CONF_DLY);
      frac <= FW'(FRAC_INIT);
    end else if (tick_o) begin
      tmr  <= TW'(BASE) + TW'(extra);
      frac <= extra ? (frac_sum - FW'(CLK_DEN)) : frac_sum;
    end else if (enable_i && tmr > TW'(1)) begin
      tmr <= tmr - TW'(1);
    end
  end

  // Gap tracking for the spacing checks
  logic [TW:0] gap, g1, g2;
  logic [1:0]  nt;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; g1 <= '0; g2 <= '0; nt <= '0;
    end else if (restart_i) begin
      gap <= (TW+1)'(1); nt <= '0;
    end else if (tick_o) begin
      g2  <= g1;
      g1  <= gap;
      gap <= (TW+1)'(1);
      nt  <= (nt == 2'd3) ? nt : nt + 2'd1;
    end else if (enable_i) begin
      gap <= gap + (TW+1)'(1);
    end
  end

  // R9
  gap_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && nt != 2'd0) |-> (int'(gap) == BASE || int'(gap) == BASE + 1));
  // R9
  gap_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && nt == 2'd3) |-> (int'(gap) + int'(g1) + int'(g2) == CLK_NUM));
endmodule

// File: rtl/lsusb_rx_nrzi.sv
module lsusb_rx_nrzi #(
  parameter int BW  = 8,
  parameter int RUN = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic          lvl_i,
  output logic          byte_vld_o,
  output logic [BW-1:0] byte_o
);
  localparam int CW  = $clog2(RUN + 1);
  localparam int BCW = $clog2(BW);

  logic           prev;
  logic [CW-1:0]  ones;
  logic [BCW-1:0] bcnt;
  logic [BW-1:0]  sh, nxt;
  logic           bit_v;

  assign bit_v = (lvl_i == prev);
  assign nxt   = {bit_v, sh[BW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0; ones <= '0; bcnt <= '0; sh <= '0;
      byte_vld_o <= 1'b0; byte_o <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (clear_i) begin
        prev <= 1'b0;        // sync ends on K, D- low
        ones <= CW'(1);      // trailing sync 1 counts toward the run
        bcnt <= '0;
      end else if (sample_i) begin
        prev <= lvl_i;
        if (ones == CW'(RUN)) begin
          ones <= '0;        // stuffed bit dropped
        end else begin
          ones <= bit_v ? ones + CW'(1) : '0;
          sh   <= nxt;
          if (bcnt == BCW'(BW - 1)) begin
            byte_vld_o <= 1'b1;
            byte_o     <= nxt;
            bcnt       <= '0;
          end else begin
            bcnt <= bcnt + BCW'(1);
          end
        end
      end
    end
  end

  // R5
  run_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ones <= CW'(RUN));
  // R5
  stuff_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_i && !clear_i && ones == CW'(RUN)) |=> !byte_vld_o);
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
  import lsusb_rx_pkg::*;
#(
  parameter int BUF_DEPTH   = 8,
  parameter int CLK_NUM     = 32,
  parameter int CLK_DEN     = 3,
  parameter int SYNC_WINDOW = 120,
  localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dp_i,
  input  logic          dm_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          eop_o,
  output logic [LW-1:0] rx_len_o,
  output logic          ovf_o,
  output logic          sync_err_o
);
  localparam int CONF_DLY = (3 * CLK_NUM) / (2 * CLK_DEN);
  localparam int WW       = $clog2(SYNC_WINDOW + 1);

  logic [1:0] line_s;
  line_t      line, prev_line;
  rx_state_t  state;
  logic [WW-1:0] win;
  logic [LW-1:0] cnt;
  logic       edge_jk, tick, restart, enable, dec_clear, dec_sample;
  logic       byte_vld;
  logic [7:0] byte_q;
  logic       win_end;

  lsusb_rx_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i({dp_i, dm_i}), .q_o(line_s));

  assign line    = line_t'(line_s);
  assign edge_jk = (prev_line == LN_J) && (line == LN_K);
  assign win_end = (win == WW'(SYNC_WINDOW - 1));
  assign restart = edge_jk && ((state == ST_IDLE) || (state == ST_HUNT && !win_end));
  assign enable  = (state == ST_CONFIRM) || (state == ST_RECV);
  assign dec_clear  = (state == ST_CONFIRM) && tick && (line == LN_K);
  assign dec_sample = (state == ST_RECV) && tick && (line != LN_SE0);

  lsusb_rx_phase #(.CLK_NUM(CLK_NUM), .CLK_DEN(CLK_DEN), .CONF_DLY(CONF_DLY)) u_phase (
    .clk(clk), .rst(rst), .restart_i(restart), .enable_i(enable), .tick_o(tick));

  lsusb_rx_nrzi #(.BW(8), .RUN(6)) u_nrzi (
    .clk(clk), .rst(rst), .clear_i(dec_clear), .sample_i(dec_sample),
    .lvl_i(line_s[0]), .byte_vld_o(byte_vld), .byte_o(byte_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; prev_line <= LN_J; win <= '0; cnt <= '0;
      wr_en_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      eop_o <= 1'b0; rx_len_o <= '0; ovf_o <= 1'b0; sync_err_o <= 1'b0;
    end else begin
      prev_line  <= line;
      wr_en_o    <= 1'b0;
      eop_o      <= 1'b0;
      ovf_o      <= 1'b0;
      sync_err_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          win <= '0;
          if (edge_jk) state <= ST_CONFIRM;
        end
        ST_HUNT: begin
          win <= win + WW'(1);
          if (win_end) begin
            sync_err_o <= 1'b1;
            state      <= ST_DRAIN;
          end else if (edge_jk) begin
            state <= ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          win <= win + WW'(1);
          if (tick && line == LN_K) begin
            state <= ST_RECV;
          end else if (win_end) begin
            sync_err_o <= 1'b1;
            state      <= ST_DRAIN;
          end else if (tick) begin
            state <= ST_HUNT;
          end
        end
        ST_RECV: begin
          if (tick && line == LN_SE0) begin
            eop_o    <= 1'b1;
            rx_len_o <= cnt;
            state    <= ST_IDLE;
          end else if (byte_vld) begin
            if (cnt == LW'(BUF_DEPTH)) begin
              ovf_o <= 1'b1;
              state <= ST_DRAIN;
            end else begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= cnt[AW-1:0];
              wr_data_o <= byte_q;
              cnt       <= cnt + LW'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (line == LN_SE0) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  lock_on_k_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV && $past(state) == ST_CONFIRM) |-> $past(line) == LN_K);
  // R3
  sync_err_clean_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err_o |-> (cnt == '0 && state == ST_DRAIN));
  // R7
  eop_len_chk: assert property (@(posedge clk) disable iff (rst)
    eop_o |-> rx_len_o <= LW'(BUF_DEPTH));
  // R8
  ovf_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> (!wr_en_o && !eop_o));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en_o, eop_o, ovf_o, sync_err_o}));
endmodule

// File: tb/lsusb_rx_tb_top.sv
module lsusb_rx_tb_top;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1, dp = 1'b0, dm = 1'b1;
  logic          wr_en, eop, ovf, serr;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [LW-1:0] rx_len;

  always #4 clk = ~clk;

  lsusb_rx #(.BUF_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .dp_i(dp), .dm_i(dm),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .eop_o(eop), .rx_len_o(rx_len), .ovf_o(ovf), .sync_err_o(serr));

  int n_tests = 0, n_fail = 0, cyc = 0, wr_idx = 0, ph = 0;
  int exp_ovf = 0, got_ovf = 0, exp_serr = 0, got_serr = 0, exp_eop = 0, got_eop = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic [7:0] data_q[$];
  int exp_len_q[$];
  int lvl_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: compared on every clock
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if ((int'(wr_en) + int'(eop) + int'(ovf) + int'(serr)) > 1)
        check(0, "R10 strobes exclusive", int'({wr_en, eop, ovf, serr}), 0);
      if (wr_en) begin
        if (exp_q.size() == 0) check(0, "R6 unexpected write", int'(wr_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(wr_data == e, "R4 R6 R9 byte value", int'(wr_data), int'(e));
          check(int'(wr_addr) == wr_idx, "R6 write index", int'(wr_addr), wr_idx);
          wr_idx++;
        end
      end
      if (eop) begin
        got_eop++;
        if (exp_len_q.size() == 0) check(0, "R7 unexpected end", int'(rx_len), 0);
        else begin
          int el;
          el = exp_len_q.pop_front();
          check(int'(rx_len) == el, "R7 byte count", int'(rx_len), el);
        end
        wr_idx = 0;
      end
      if (ovf)  begin got_ovf++;  wr_idx = 0; end
      if (serr) begin got_serr++; wr_idx = 0; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic set_line(input int l);
    case (l)
      0: begin dp = 1'b0; dm = 1'b0; end
      1: begin dp = 1'b0; dm = 1'b1; end
      default: begin dp = 1'b1; dm = 1'b0; end
    endcase
  endtask

  task automatic drive_levels();
    for (int k = 0; k < lvl_q.size(); k++) begin
      int dur;
      dur = ((k + 1) * 32 + ph) / 3 - (k * 32 + ph) / 3;
      set_line(lvl_q[k]);
      repeat (dur) @(negedge clk);
    end
  endtask

  task automatic push_bit(input bit b, inout int last, inout int ones);
    if (!b) last = (last == 1) ? 2 : 1;
    lvl_q.push_back(last);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      last = (last == 1) ? 2 : 1;
      lvl_q.push_back(last);
      ones = 0;
    end
  endtask

  task automatic send_packet(input int extra_pairs, input int extra_bits);
    int last, ones, n;
    lvl_q.delete();
    for (int i = 0; i < extra_pairs; i++) begin lvl_q.push_back(2); lvl_q.push_back(1); end
    lvl_q.push_back(2); lvl_q.push_back(1); lvl_q.push_back(2); lvl_q.push_back(1);
    lvl_q.push_back(2); lvl_q.push_back(1); lvl_q.push_back(2); lvl_q.push_back(2);
    last = 2; ones = 1;
    n = data_q.size();
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) push_bit(data_q[i][j], last, ones);
    for (int j = 0; j < extra_bits; j++) push_bit(j[0], last, ones);
    lvl_q.push_back(0); lvl_q.push_back(0);
    for (int i = 0; i < 4; i++) lvl_q.push_back(1);
    for (int i = 0; i < n && i < DEPTH; i++) exp_q.push_back(data_q[i]);
    if (n > DEPTH) exp_ovf++;
    else begin exp_len_q.push_back(n); exp_eop++; end
    drive_levels();
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 all bytes written", exp_q.size(), 0);
    check(got_eop == exp_eop, "R7 end strobes", got_eop, exp_eop);
    check(got_ovf == exp_ovf, "R8 overflow strobes", got_ovf, exp_ovf);
    check(got_serr == exp_serr, "R2 R3 sync errors", got_serr, exp_serr);
  endtask

  initial begin
    set_line(1);
    repeat (5) @(negedge clk);
    check({wr_en, eop, ovf, serr} == 4'b0, "R1 reset strobes", int'({wr_en, eop, ovf, serr}), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check({wr_en, eop, ovf, serr, rx_len} == '0, "R1 idle outputs", int'(rx_len), 0);

    // R4 R6 R7: plain packet
    data_q = '{8'hC3, 8'h5A, 8'h00};
    send_packet(0, 0);
    // R5: stuffing, including the run that starts in the sync field
    data_q = '{8'h1F, 8'hFF, 8'hFF, 8'h7E};
    send_packet(0, 0);
    // R9: full buffer, different phase, no resync
    ph = 1;
    data_q = '{8'h01, 8'h80, 8'hAA, 8'h55, 8'hF0, 8'h0F, 8'hE7, 8'h3C};
    send_packet(0, 0);
    ph = 2;
    data_q = '{8'h96, 8'h69, 8'hB4, 8'h2D, 8'hFE, 8'h01, 8'h77, 8'h88};
    send_packet(0, 0);
    // R2: extra leading K-J pair before the double K
    ph = 0;
    data_q = '{8'h4B, 8'hD2};
    send_packet(1, 0);
    // R7: trailing partial byte discarded; zero-byte packet
    data_q = '{8'h12};
    send_packet(0, 3);
    data_q.delete();
    send_packet(0, 0);
    // R8: overflow
    data_q = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76, 8'h87, 8'h98, 8'hA9};
    send_packet(0, 0);
    data_q = '{8'h5C};
    send_packet(0, 0);
    // R3: edge never followed by a double K
    exp_serr++;
    set_line(2); repeat (11) @(negedge clk);
    set_line(1); repeat (200) @(negedge clk);
    check(got_serr == exp_serr, "R3 sync error pulse", got_serr, exp_serr);
    set_line(2); repeat (30) @(negedge clk);
    set_line(0); repeat (22) @(negedge clk);
    set_line(1); repeat (40) @(negedge clk);
    check(got_eop == exp_eop, "R3 no end strobe after abort", got_eop, exp_eop);
    check(got_serr == exp_serr, "R3 single error pulse", got_serr, exp_serr);
    // recovery
    data_q = '{8'hC0, 8'h3F};
    send_packet(0, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule